// File: doc/BRIEF.md
# Program Counter Sequencer

This block produces the instruction fetch address for a Harvard machine that completes one instruction per cycle, with no separate fetch step. On every update edge the address register moves to one of three places. It can step to the next word. It can load a 16-bit target held in a memory-mapped destination register. It can return to address zero. The jump and return strobes come from instruction decode, and the chosen source takes effect on the same edge that updates the processor registers.

A write of 1 to the halt location freezes the counter. It stays frozen until the asynchronous reset, and reset always restarts execution at address 0. The block has no call stack. Return always goes to address zero, and every jump takes its target from the destination register. Instruction memory and decode sit outside the block.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_ni is low and on the first sample after it rises, pc_o is 0.
- R2: On an edge with no jump, no return and no halt, pc_o becomes its previous value plus one.
- R3: Stepping from the all-ones address (0xFFFF at default width) wraps pc_o to 0.
- R4: On an edge with jump_i high and ret_i low, pc_o becomes jump_dest_i, zero-extended to the counter width.
- R5: On an edge with ret_i high, pc_o becomes 0.
- R6: When jump_i and ret_i are both high on one edge, return wins and pc_o becomes 0.
- R7: On an edge with halt_wr_i high and halt_data_i equal to 1, pc_o keeps its value, and it keeps that value on every later edge.
- R8: Once halted, jump_i and ret_i have no effect and pc_o does not change.
- R9: A halt write with halt_data_i equal to 0 is ignored, and the counter keeps stepping.
- R10: Reset clears the halted state, and execution restarts at address 0 and steps from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Update-phase clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| jump_i | input | 1 | Jump strobe from decode |
| ret_i | input | 1 | Return strobe from decode |
| halt_wr_i | input | 1 | Write strobe to the halt location |
| halt_data_i | input | 1 | Data bit written to the halt location |
| jump_dest_i | input | 16 | Contents of the memory-mapped jump destination register |
| pc_o | output | PC_W (16) | Instruction fetch address |

## Verification
Every fault in this block appears on pc_o at the next update edge, because the address is driven straight from its register. A halted flag that sticks, or one that is lost, shows as pc_o frozen or stepping one edge after the halt write or after reset. A wrong source priority shows as a jump target appearing where a return should give zero. A wrong carry or width shows only at the all-ones boundary, so the bench reaches that boundary with a jump instead of counting up to it.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [1:0] {
    SEL_INC  = 2'd0,
    SEL_JUMP = 2'd1,
    SEL_ZERO = 2'd2,
    SEL_HOLD = 2'd3
  } next_sel_e;
endpackage

// File: rtl/pc_seq_halt_latch.sv
module pc_seq_halt_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic data_i,
  output logic halt_set_o,
  output logic halted_o
);
  logic halted_q;

  assign halt_set_o = wr_i & data_i;
  assign halted_o   = halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         halted_q <= 1'b0;
    else if (halt_set_o) halted_q <= 1'b1;
  end

  // R7
  halt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && data_i) |=> halted_o);
  // R8
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  // R9
  halt_zero_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !(wr_i && data_i)) |=> !halted_o);
endmodule

// File: rtl/pc_seq_next_sel.sv
module pc_seq_next_sel
  import pc_seq_pkg::*;
(
  input  logic      halted_i,
  input  logic      halt_set_i,
  input  logic      jump_i,
  input  logic      ret_i,
  output next_sel_e sel_o
);
  // priority: halt, return, jump, step
  always_comb begin
    if (halted_i || halt_set_i) sel_o = SEL_HOLD;
    else if (ret_i)             sel_o = SEL_ZERO;
    else if (jump_i)            sel_o = SEL_JUMP;
    else                        sel_o = SEL_INC;
  end
endmodule

// File: rtl/pc_seq_addr_mux.sv
module pc_seq_addr_mux
  import pc_seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DEST_W = 16
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DEST_W-1:0] dest_i,
  input  next_sel_e         sel_i,
  output logic [PC_W-1:0]   pc_next_o
);
  localparam int PAD_W = PC_W - DEST_W;

  logic [PC_W-1:0] dest_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign dest_ext = {{PAD_W{1'b0}}, dest_i};
    end else begin : g_trunc
      assign dest_ext = dest_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      SEL_INC:  pc_next_o = pc_i + PC_W'(1);
      SEL_JUMP: pc_next_o = dest_ext;
      SEL_ZERO: pc_next_o = '0;
      default:  pc_next_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DEST_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              jump_i,
  input  logic              ret_i,
  input  logic              halt_wr_i,
  input  logic              halt_data_i,
  input  logic [DEST_W-1:0] jump_dest_i,
  output logic [PC_W-1:0]   pc_o
);
  logic            halted;
  logic            halt_set;
  next_sel_e       sel;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  pc_seq_halt_latch u_halt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (halt_wr_i),
    .data_i     (halt_data_i),
    .halt_set_o (halt_set),
    .halted_o   (halted)
  );

  pc_seq_next_sel u_sel (
    .halted_i   (halted),
    .halt_set_i (halt_set),
    .jump_i     (jump_i),
    .ret_i      (ret_i),
    .sel_o      (sel)
  );

  pc_seq_addr_mux #(.PC_W(PC_W), .DEST_W(DEST_W)) u_mux (
    .pc_i      (pc_q),
    .dest_i    (jump_dest_i),
    .sel_i     (sel),
    .pc_next_o (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted && !jump_i && !ret_i && !(halt_wr_i && halt_data_i))
      |=> pc_o == $past(pc_o) + PC_W'(1));
  // R4
  jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted && jump_i && !ret_i && !(halt_wr_i && halt_data_i))
      |=> pc_o[DEST_W-1:0] == $past(jump_dest_i));
  // R5
  ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted && ret_i && !(halt_wr_i && halt_data_i)) |=> pc_o == '0);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted || (halt_wr_i && halt_data_i)) |=> $stable(pc_o));
endmodule

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  // {jump, ret, halt_wr, halt_data, dest[15:0], expected[15:0], req[7:0]}
  localparam int VW = 4 + 16 + 16 + 8;
  localparam logic [VW-1:0] VECS [NVEC] = '{
    {4'b0000, 16'h0000, 16'h0001, 8'd2},  // R2
    {4'b0000, 16'h0000, 16'h0002, 8'd2},  // R2
    {4'b1000, 16'h1234, 16'h1234, 8'd4},  // R4
    {4'b0000, 16'h0000, 16'h1235, 8'd2},  // R2
    {4'b0100, 16'h0000, 16'h0000, 8'd5},  // R5
    {4'b0000, 16'h0000, 16'h0001, 8'd2},  // R2
    {4'b1100, 16'h5555, 16'h0000, 8'd6},  // R6
    {4'b1000, 16'hFFFF, 16'hFFFF, 8'd4},  // R4
    {4'b0000, 16'h0000, 16'h0000, 8'd3},  // R3
    {4'b0000, 16'h0000, 16'h0001, 8'd2},  // R2
    {4'b0010, 16'h0000, 16'h0002, 8'd9},  // R9
    {4'b0011, 16'h0000, 16'h0002, 8'd7},  // R7
    {4'b0000, 16'h0000, 16'h0002, 8'd7},  // R7
    {4'b1000, 16'h00AA, 16'h0002, 8'd8},  // R8
    {4'b0100, 16'h0000, 16'h0002, 8'd8}   // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jump = 1'b0, ret = 1'b0, hwr = 1'b0, hdat = 1'b0;
  logic [15:0] dest = '0;
  logic [15:0] pc;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .jump_i(jump), .ret_i(ret),
    .halt_wr_i(hwr), .halt_data_i(hdat), .jump_dest_i(dest), .pc_o(pc)
  );

  task automatic check(input logic [15:0] exp, input string tag);
    checks++;
    if (pc !== exp) begin
      errors++;
      $display("FAIL %s: pc_o actual=%h expected=%h", tag, pc, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(16'h0000, "R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      {jump, ret, hwr, hdat} = VECS[i][VW-1 -: 4];
      dest = VECS[i][VW-5 -: 16];
      @(negedge clk);
      check(VECS[i][23:8], $sformatf("vec %0d R%0d", i, VECS[i][7:0]));
    end
    {jump, ret, hwr, hdat} = 4'b0000;
    // R10: reset leaves halt and restarts at 0
    rst_n = 1'b0;
    @(negedge clk);
    check(16'h0000, "R10 reset while halted");
    rst_n = 1'b1;
    @(negedge clk);
    check(16'h0001, "R10 steps after reset");
    @(negedge clk);
    check(16'h0002, "R10 keeps stepping");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule